// File: doc/BRIEF.md
# Processor interrupt level arbiter

This block decides which levelled external interrupt, if any, a processor core should take. It merges the hardware interrupt lines with a software-pending register. Two timer-match bits in that register do not appear as levels of their own; they raise level 14. The merged vector is then compared against the core's current interrupt level. Every clock, from the values sampled on its inputs, the arbiter either raises, keeps or withdraws a registered interrupt request and the trap type that goes with it.

The trap type for level L is the external-interrupt base code 0x40 ORed with L, so levels 1 to 15 give 0x41 to 0x4F. A pending vector interrupt outranks every levelled interrupt, and while it is busy the arbiter freezes. A nested trap that is already servicing a higher external-interrupt trap type blocks a new, lower request. Trap entry, the trap stack and writes to the software register belong to other logic and reach this block only as inputs.

Top module: `pil_arb`

## Requirements
- R1: The pending vector is `irq_lines` ORed with `soft_pend`, where the timer-match bit (soft_pend bit 0) and the system-timer-match bit (soft_pend bit 15) take no part in the OR.
- R2: If soft_pend bit 0 or bit 15 is set, bit 14 of the pending vector is set.
- R3: While `vec_busy` is sampled high, `irq_req` and `irq_tt` keep their values on the next clock.
- R4: When `vec_busy` is low and the pending vector, read as an unsigned number, is below 2 << `cur_pil`, the next clock clears `irq_req` and sets `irq_tt` to 0.
- R5: When `vec_busy` is low, `int_en` is high and R4 does not apply, the candidate is the highest set pending bit above `cur_pil`, and its trap type is 0x40 | level (bits 8:4 = 0x04, bits 3:0 = level).
- R6: If `trap_lvl` is non-zero, `trap_type_now` bits 8:4 equal 0x04 and `trap_type_now` is greater than the candidate trap type, the next clock leaves `irq_req` and `irq_tt` unchanged.
- R7: Otherwise the candidate trap type is loaded into `irq_tt` and `irq_req` is set on the next clock; the request stays high until R4 or R8 clears it, and `irq_req` is high exactly when `irq_tt` is non-zero.
- R8: When `vec_busy` is low, R4 does not apply and `int_en` is low, the next clock clears `irq_req` and sets `irq_tt` to 0.
- R9: After reset `irq_req` is 0 and `irq_tt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Hardware level request lines, bit n is level n |
| soft_pend | input | 16 | Software-pending levels; bit 0 timer match, bit 15 system-timer match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_type_now | input | 9 | Trap type currently being serviced |
| vec_busy | input | 1 | A vector interrupt is pending and outranks levels |
| irq_req | output | 1 | Registered interrupt request, held until cleared |
| irq_tt | output | 9 | Trap type to take; 0 when no request |

## Verification
The assertions check on every cycle the freeze under a busy vector interrupt, the clearing below the level threshold and with interrupts disabled, the form of the stored trap type, and the pairing of request and trap type. Which level wins among several pending bits, the folding of the two timer bits into level 14, and the suppression under a nested external trap depend on the data pattern, so only the bench's sweeps over every level against every interrupt level, every software bit, and a long pseudo-random run compared against an arithmetic model can show them.

// File: rtl/pil_arb_pkg.sv
package pil_arb_pkg;
  localparam int unsigned DEF_LEVELS   = 16;
  localparam int unsigned DEF_TT_W     = 9;
  localparam int unsigned DEF_TL_W     = 3;
  localparam int unsigned DEF_TICK_BIT = 0;
  localparam int unsigned DEF_STCK_BIT = 15;
  localparam int unsigned DEF_FOLD_LVL = 14;
  localparam logic [8:0]  DEF_EXT_BASE = 9'h040;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2
  } arb_act_e;
endpackage

// File: rtl/pil_pend.sv
module pil_pend #(
  parameter int unsigned LEVELS   = 16,
  parameter int unsigned TICK_BIT = 0,
  parameter int unsigned STCK_BIT = 15,
  parameter int unsigned FOLD_LVL = 14
) (
  input  logic [LEVELS-1:0] hw_lines,
  input  logic [LEVELS-1:0] sw_lines,
  output logic [LEVELS-1:0] pend
);
  localparam logic [LEVELS-1:0] TMR_MASK =
    (LEVELS'(1) << TICK_BIT) | (LEVELS'(1) << STCK_BIT);

  logic tmr_hit;

  always_comb begin
    tmr_hit = |(sw_lines & TMR_MASK);
    pend    = hw_lines | (sw_lines & ~TMR_MASK);
    if (tmr_hit) pend[FOLD_LVL] = 1'b1;
  end
endmodule

// File: rtl/pil_pick.sv
module pil_pick #(
  parameter int unsigned LEVELS = 16,
  localparam int unsigned LW    = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] pend,
  input  logic [LW-1:0]     floor_lvl,
  output logic              found,
  output logic [LW-1:0]     win_lvl
);
  logic [LEVELS-1:0] above;
  logic [LEVELS-1:0] elig;

  for (genvar g = 0; g < LEVELS; g++) begin : g_above
    assign above[g] = (LW'(g) > floor_lvl);
  end

  assign elig = pend & above;

  always_comb begin
    found   = 1'b0;
    win_lvl = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (elig[i]) begin
        found   = 1'b1;
        win_lvl = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pil_arb.sv
module pil_arb
  import pil_arb_pkg::*;
#(
  parameter int unsigned LEVELS   = DEF_LEVELS,
  parameter int unsigned TT_W     = DEF_TT_W,
  parameter int unsigned TL_W     = DEF_TL_W,
  parameter int unsigned TICK_BIT = DEF_TICK_BIT,
  parameter int unsigned STCK_BIT = DEF_STCK_BIT,
  parameter int unsigned FOLD_LVL = DEF_FOLD_LVL,
  parameter logic [TT_W-1:0] EXT_BASE = TT_W'(DEF_EXT_BASE),
  localparam int unsigned LW = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] irq_lines,
  input  logic [LEVELS-1:0] soft_pend,
  input  logic [LW-1:0]     cur_pil,
  input  logic              int_en,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [TT_W-1:0]   trap_type_now,
  input  logic              vec_busy,
  output logic              irq_req,
  output logic [TT_W-1:0]   irq_tt
);
  localparam int unsigned THR_W = LEVELS + 1;

  logic [LEVELS-1:0] pend;
  logic [THR_W-1:0]  thresh;
  logic              below;
  logic              found;
  logic [LW-1:0]     win_lvl;
  logic [TT_W-1:0]   cand_tt;
  logic              nest_block;
  arb_act_e          act;

  logic              req_q, req_d;
  logic [TT_W-1:0]   tt_q, tt_d;
  logic              upd_en;

  pil_pend #(
    .LEVELS(LEVELS), .TICK_BIT(TICK_BIT),
    .STCK_BIT(STCK_BIT), .FOLD_LVL(FOLD_LVL)
  ) i_pend (
    .hw_lines (irq_lines),
    .sw_lines (soft_pend),
    .pend     (pend)
  );

  pil_pick #(.LEVELS(LEVELS)) i_pick (
    .pend      (pend),
    .floor_lvl (cur_pil),
    .found     (found),
    .win_lvl   (win_lvl)
  );

  // Threshold: any set bit above the current level makes the vector reach 2<<pil.
  assign thresh  = THR_W'(2) << cur_pil;
  assign below   = ({1'b0, pend} < thresh);
  assign cand_tt = EXT_BASE | TT_W'(win_lvl);

  // A nested external trap of higher type keeps the new candidate out.
  assign nest_block = (trap_lvl != '0) &&
                      (trap_type_now[TT_W-1:4] == EXT_BASE[TT_W-1:4]) &&
                      (trap_type_now > cand_tt);

  always_comb begin
    act = ACT_HOLD;
    if (vec_busy) begin
      act = ACT_HOLD;
    end else if (below) begin
      act = ACT_CLEAR;
    end else if (int_en) begin
      if (found && !nest_block && (cand_tt != tt_q)) act = ACT_LOAD;
    end else if (req_q) begin
      act = ACT_CLEAR;
    end
  end

  always_comb begin
    upd_en = (act != ACT_HOLD);
    req_d  = req_q;
    tt_d   = tt_q;
    case (act)
      ACT_CLEAR: begin req_d = 1'b0; tt_d = '0;      end
      ACT_LOAD:  begin req_d = 1'b1; tt_d = cand_tt; end
      default:   begin req_d = req_q; tt_d = tt_q;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else if (upd_en) begin
      req_q <= req_d;
      tt_q  <= tt_d;
    end
  end

  assign irq_req = req_q;
  assign irq_tt  = tt_q;

  // R3: a busy vector interrupt freezes the outputs
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

  // R4: a vector under the threshold clears request and trap type
  p_below_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && below) |=> (!irq_req && irq_tt == '0));

  // R8: disabling interrupts withdraws the request
  p_off_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_busy && !int_en) |=> (!irq_req && irq_tt == '0));

  // R5: a stored trap type is an external-interrupt code above the level in force
  p_tt_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_tt[TT_W-1:4] == EXT_BASE[TT_W-1:4] && irq_tt[3:0] != 4'd0));

  p_tt_above_pil_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tt != $past(irq_tt) && irq_tt != '0) |-> (irq_tt[3:0] > 4'($past(cur_pil))));

  // R7: request and trap type travel together
  p_req_tt_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_tt != '0));
endmodule

// File: tb/test_pil_arb.sv
module test_pil_arb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic [15:0] soft_pend;
  logic [3:0]  cur_pil;
  logic        int_en;
  logic [2:0]  trap_lvl;
  logic [8:0]  trap_type_now;
  logic        vec_busy;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       m_req;
  logic [8:0] m_tt;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  pil_arb i_pil_arb (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .soft_pend(soft_pend),
    .cur_pil(cur_pil), .int_en(int_en), .trap_lvl(trap_lvl),
    .trap_type_now(trap_type_now), .vec_busy(vec_busy),
    .irq_req(irq_req), .irq_tt(irq_tt)
  );

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Model built from the requirements; returns the tag of the rule applied.
  function automatic string model_step();
    logic [15:0] pv;
    int          hi;
    logic [8:0]  cand;
    pv = irq_lines | (soft_pend & 16'h7FFE);                 // R1
    if (soft_pend[0] || soft_pend[15]) pv[14] = 1'b1;        // R2
    if (vec_busy) return "R3";
    if (32'(pv) < (32'd2 << cur_pil)) begin
      m_req = 1'b0; m_tt = 9'd0; return "R4";
    end
    if (!int_en) begin
      m_req = 1'b0; m_tt = 9'd0; return "R8";
    end
    hi = -1;
    for (int i = 15; i > int'(cur_pil); i--) begin
      if (pv[i] && hi < 0) hi = i;
    end
    cand = 9'h040 + 9'(hi);
    if (trap_lvl != 3'd0 && trap_type_now[8:4] == 5'h04 && trap_type_now > cand)
      return "R6";
    if (cand != m_tt) begin
      m_req = 1'b1; m_tt = cand; return "R5";
    end
    return "R7";
  endfunction

  task automatic compare(input string tag, input string what);
    checks++;
    if (irq_req !== m_req || irq_tt !== m_tt) begin
      errors++;
      $display("FAIL %s %s: req=%0b tt=0x%03h expected req=%0b tt=0x%03h",
               tag, what, irq_req, irq_tt, m_req, m_tt);
    end
  endtask

  task automatic apply(input logic [15:0] hw, input logic [15:0] sw,
                       input logic [3:0] pil, input logic en,
                       input logic [2:0] tl, input logic [8:0] ctt,
                       input logic busy, input string what);
    string tag;
    irq_lines = hw; soft_pend = sw; cur_pil = pil; int_en = en;
    trap_lvl = tl; trap_type_now = ctt; vec_busy = busy;
    tag = model_step();
    @(negedge clk);
    compare(tag, what);
  endtask

  initial begin
    rst_n = 1'b0;
    irq_lines = '0; soft_pend = '0; cur_pil = '0; int_en = 1'b0;
    trap_lvl = '0; trap_type_now = '0; vec_busy = 1'b0;
    m_req = 1'b0; m_tt = 9'd0;
    repeat (3) @(negedge clk);
    compare("R9", "reset state");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9", "after reset release");

    // Every single level against every interrupt level, enabled and disabled.
    for (int p = 0; p < 16; p++)
      for (int b = 0; b < 16; b++)
        for (int e = 1; e >= 0; e--)
          apply(16'(1) << b, 16'h0, 4'(p), e[0], 3'd0, 9'd0, 1'b0, "level sweep R5");

    // Every software bit alone: timer bits fold to level 14 (R1, R2).
    for (int p = 0; p < 16; p += 13)
      for (int b = 0; b < 16; b++) begin
        apply(16'h0, 16'h0, 4'(p), 1'b1, 3'd0, 9'd0, 1'b0, "clear");
        apply(16'h0, 16'(1) << b, 4'(p), 1'b1, 3'd0, 9'd0, 1'b0, "soft bit R1 R2");
      end

    // Highest of several bits wins; request holds across repeats (R5, R7).
    apply(16'h0000, 16'h0, 4'd0, 1'b1, 3'd0, 9'd0, 1'b0, "clear");
    apply(16'h0226, 16'h0, 4'd2, 1'b1, 3'd0, 9'd0, 1'b0, "multi-bit R5");
    apply(16'h0226, 16'h0, 4'd2, 1'b1, 3'd0, 9'd0, 1'b0, "repeat hold R7");
    apply(16'h8001, 16'h0, 4'd14, 1'b1, 3'd0, 9'd0, 1'b0, "level 15 R5");

    // Nested external trap (R6).
    apply(16'h0, 16'h0, 4'd0, 1'b1, 3'd0, 9'd0, 1'b0, "clear");
    apply(16'h0020, 16'h0, 4'd0, 1'b1, 3'd1, 9'h04A, 1'b0, "nested higher R6");
    apply(16'h0020, 16'h0, 4'd0, 1'b1, 3'd1, 9'h030, 1'b0, "nested non-ext R6");
    apply(16'h0800, 16'h0, 4'd0, 1'b1, 3'd2, 9'h04A, 1'b0, "nested lower R6");
    apply(16'h0020, 16'h0, 4'd0, 1'b1, 3'd0, 9'h04F, 1'b0, "tl zero R6");

    // Busy vector interrupt freezes everything (R3).
    apply(16'h0000, 16'h0, 4'd0, 1'b0, 3'd0, 9'd0, 1'b1, "busy no clear R3");
    apply(16'h4000, 16'h0, 4'd0, 1'b1, 3'd0, 9'd0, 1'b1, "busy no load R3");
    apply(16'h0000, 16'h0, 4'd0, 1'b1, 3'd0, 9'd0, 1'b0, "below clears R4");
    apply(16'h0100, 16'h0, 4'd3, 1'b1, 3'd0, 9'd0, 1'b0, "load");
    apply(16'h0100, 16'h0, 4'd3, 1'b0, 3'd0, 9'd0, 1'b0, "disable clears R8");

    // Pseudo-random mix.
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b2;
      rng = next_rng(rng); a  = rng;
      rng = next_rng(rng); b2 = rng;
      apply(a[15:0] & (a[16] ? 16'hFFFF : 16'h0F0F),
            b2[8] ? b2[31:16] : 16'h0,
            a[23:20], a[24] | a[25], b2[2:0] & {3{b2[3]}},
            {b2[4], b2[5], 2'b00, b2[7:6], b2[12:10]} | 9'h040 & {9{b2[9]}},
            (b2[15:13] == 3'd0), "random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expected=finished actual=hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule